// File: doc/BRIEF.md
# In-Order Memory Operation Queue

This block is a circular queue that holds every load and store of an out-of-order core in program order. The core serialises all memory operations through it. An entry is allocated at the tail when the operation is dispatched. The slot index it receives is returned as a tag. The effective address arrives later, in dataflow order, and for a store so does the data. Each one is written into the slot named by its tag.

Only the operation at the head of the queue may present a request to the data cache. A load at the head requests as soon as its address is known. After its access it waits for its own retirement, and its slot is then freed. A store at the head requests only when its address and data are both known and it is the oldest instruction in the reorder buffer. The cache write is the store's retirement, and its slot is freed in the same cycle the request is accepted.

The dispatch side and the cache request side are valid/ready interfaces. Dispatch is accepted in a cycle where `disp_valid` and `disp_ready` are both high. `disp_ready` is low while the queue is full or a flush is asserted. A cache request is taken in a cycle where `req_valid` and `req_ready` are both high. A raised load request keeps its valid and payload until it is taken or flushed. A store request also depends on the reorder-buffer head staying on that store, which a reorder buffer guarantees because it cannot retire past an unperformed store. The writeback, reorder-buffer head, flush and status pins are plain level signals.

Top module: `memq_inorder`

## Requirements
- R1: After reset the queue is empty (`q_empty`=1), `disp_ready`=1, `req_valid`=0 and `head_free`=0.
- R2: An accepted dispatch returns in `disp_tag` the current tail slot index; successive tags count up modulo DEPTH; with DEPTH entries held and none freed, `disp_ready` is 0.
- R3: An address or data writeback updates the live slot whose index equals its tag; a writeback to a slot that holds no entry has no effect.
- R4: Only the head entry may request; a younger entry with all operands known raises no request while an older entry is unresolved, so requests leave in program order.
- R5: A load at the head raises `req_valid` with `req_is_store`=0 in the cycle after its address is written, independent of the reorder-buffer head inputs.
- R6: A store at the head raises `req_valid` with `req_is_store`=1 only when its address and data are written and `rob_head_valid`=1 with `rob_head_id` equal to its reorder-buffer id; when that request is accepted `head_free` pulses in the same cycle and the slot is freed.
- R7: After a load request is accepted the load is not requested again; its slot is freed (`head_free`=1) in a cycle where `rob_head_valid`=1 and `rob_head_id` equals the load's id.
- R8: While `req_valid`=1, `req_ready`=0, no flush is asserted and the request is a load, `req_valid` stays 1 and `req_addr` holds its value in the next cycle.
- R9: Asserting `flush` for one cycle discards all entries: in the next cycle `q_empty`=1, `disp_ready`=1 and `req_valid`=0. During the flush cycle no dispatch is accepted and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all entries |
| disp_valid | input | 1 | Dispatch offer |
| disp_ready | output | 1 | Queue can accept a dispatch |
| disp_is_store | input | 1 | 1 = store, 0 = load |
| disp_rob_id | input | ROB_W | Reorder-buffer id of the dispatched operation |
| disp_tag | output | IDX_W | Slot index given to the dispatched operation |
| addr_wb_valid | input | 1 | Address writeback strobe |
| addr_wb_tag | input | IDX_W | Slot for the address |
| addr_wb_addr | input | ADDR_W | Effective address |
| data_wb_valid | input | 1 | Store data writeback strobe |
| data_wb_tag | input | IDX_W | Slot for the data |
| data_wb_data | input | DATA_W | Store data |
| rob_head_valid | input | 1 | Reorder-buffer head is occupied |
| rob_head_id | input | ROB_W | Id of the oldest reorder-buffer instruction |
| req_valid | output | 1 | Cache request offer |
| req_ready | input | 1 | Cache accepts the request |
| req_is_store | output | 1 | Request is a store write |
| req_addr | output | ADDR_W | Request address |
| req_data | output | DATA_W | Store data (don't-care for loads) |
| req_rob_id | output | ROB_W | Reorder-buffer id of the request |
| head_free | output | 1 | Head slot is freed this cycle |
| q_empty | output | 1 | Queue holds no entries |

## Verification
A corrupted pointer or wrap bit shows up at `disp_tag` on the next dispatch, or as `disp_ready` dropping at the wrong occupancy. A stale per-slot flag shows up as a request raised a cycle early or from a slot that is not the head. Both are visible within one or two cycles of the stimulus that exposes them. A wrong head selection or a missing done mark shows up as an out-of-order address on `req_addr` or a repeated load request. A store that ignores the reorder-buffer head shows up as `req_valid` with no matching `rob_head_id`. The directed scenarios look for each of these within a few cycles of the event that should trigger them.

// File: rtl/memq_pkg.sv
package memq_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } mem_op_e;

  function automatic int unsigned idx_bits(input int unsigned depth);
    return (depth < 2) ? 1 : $clog2(depth);
  endfunction
endpackage

// File: rtl/memq_ptrs.sv
module memq_ptrs #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned IDX_W = memq_pkg::idx_bits(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty
);
  logic [IDX_W:0] head_q, tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (flush) begin
      tail_q <= head_q;
    end else begin
      if (push) tail_q <= tail_q + 1'b1;
      if (pop)  head_q <= head_q + 1'b1;
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign empty    = (head_q == tail_q);
  assign full     = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                    (head_q[IDX_W] != tail_q[IDX_W]);
endmodule

// File: rtl/memq_slots.sv
module memq_slots #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROB_W  = 6,
  localparam int unsigned IDX_W = memq_pkg::idx_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc,
  input  logic [IDX_W-1:0]  tail_idx,
  input  logic              alloc_is_store,
  input  logic [ROB_W-1:0]  alloc_rob_id,
  input  logic              addr_wb_valid,
  input  logic [IDX_W-1:0]  addr_wb_tag,
  input  logic [ADDR_W-1:0] addr_wb_addr,
  input  logic              data_wb_valid,
  input  logic [IDX_W-1:0]  data_wb_tag,
  input  logic [DATA_W-1:0] data_wb_data,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic              mark_done,
  input  logic              free,
  output logic              hd_is_store,
  output logic [ROB_W-1:0]  hd_rob_id,
  output logic [ADDR_W-1:0] hd_addr,
  output logic [DATA_W-1:0] hd_data,
  output logic              hd_addr_ok,
  output logic              hd_data_ok,
  output logic              hd_done
);
  logic [DEPTH-1:0]  live, is_store, addr_ok, data_ok, done;
  logic [ROB_W-1:0]  rob_id [DEPTH];
  logic [ADDR_W-1:0] addr   [DEPTH];
  logic [DATA_W-1:0] data   [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic sel_alloc, sel_addr, sel_data, sel_head;
    assign sel_alloc = alloc && (tail_idx == IDX_W'(g));
    assign sel_addr  = addr_wb_valid && (addr_wb_tag == IDX_W'(g)) && live[g];
    assign sel_data  = data_wb_valid && (data_wb_tag == IDX_W'(g)) && live[g];
    assign sel_head  = (head_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        live[g]    <= 1'b0;
        addr_ok[g] <= 1'b0;
        data_ok[g] <= 1'b0;
        done[g]    <= 1'b0;
      end else begin
        if (sel_addr) addr_ok[g] <= 1'b1;
        if (sel_data) data_ok[g] <= 1'b1;
        if (mark_done && sel_head) done[g] <= 1'b1;
        if (free && sel_head) live[g] <= 1'b0;
        if (sel_alloc) begin
          live[g]    <= 1'b1;
          addr_ok[g] <= 1'b0;
          data_ok[g] <= 1'b0;
          done[g]    <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (sel_alloc) begin
        is_store[g] <= alloc_is_store;
        rob_id[g]   <= alloc_rob_id;
      end
      if (sel_addr) addr[g] <= addr_wb_addr;
      if (sel_data) data[g] <= data_wb_data;
    end
  end

  assign hd_is_store = is_store[head_idx];
  assign hd_rob_id   = rob_id[head_idx];
  assign hd_addr     = addr[head_idx];
  assign hd_data     = data[head_idx];
  assign hd_addr_ok  = live[head_idx] && addr_ok[head_idx];
  assign hd_data_ok  = data_ok[head_idx];
  assign hd_done     = live[head_idx] && done[head_idx];
endmodule

// File: rtl/memq_head.sv
module memq_head #(
  parameter int unsigned ROB_W = 6
) (
  input  logic             empty,
  input  logic             flush,
  input  logic             hd_is_store,
  input  logic [ROB_W-1:0] hd_rob_id,
  input  logic             hd_addr_ok,
  input  logic             hd_data_ok,
  input  logic             hd_done,
  input  logic             rob_head_valid,
  input  logic [ROB_W-1:0] rob_head_id,
  input  logic             req_ready,
  output logic             req_valid,
  output logic             mark_done,
  output logic             free
);
  import memq_pkg::*;
  logic at_rob_head, store_go, load_go, fire;

  always_comb begin
    at_rob_head = rob_head_valid && (rob_head_id == hd_rob_id);
    store_go    = (mem_op_e'(hd_is_store) == OP_STORE) && hd_addr_ok &&
                  hd_data_ok && at_rob_head;
    load_go     = (mem_op_e'(hd_is_store) == OP_LOAD) && hd_addr_ok && !hd_done;
    req_valid   = !empty && !flush && (store_go || load_go);
    fire        = req_valid && req_ready;
    mark_done   = fire && !hd_is_store;
    free        = !empty && !flush &&
                  (hd_is_store ? fire : (hd_done && at_rob_head));
  end
endmodule

// File: rtl/memq_inorder.sv
module memq_inorder #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ROB_W  = 6,
  localparam int unsigned IDX_W = memq_pkg::idx_bits(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              disp_valid,
  output logic              disp_ready,
  input  logic              disp_is_store,
  input  logic [ROB_W-1:0]  disp_rob_id,
  output logic [IDX_W-1:0]  disp_tag,
  input  logic              addr_wb_valid,
  input  logic [IDX_W-1:0]  addr_wb_tag,
  input  logic [ADDR_W-1:0] addr_wb_addr,
  input  logic              data_wb_valid,
  input  logic [IDX_W-1:0]  data_wb_tag,
  input  logic [DATA_W-1:0] data_wb_data,
  input  logic              rob_head_valid,
  input  logic [ROB_W-1:0]  rob_head_id,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_is_store,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [ROB_W-1:0]  req_rob_id,
  output logic              head_free,
  output logic              q_empty
);
  logic [IDX_W-1:0] head_idx, tail_idx;
  logic full, empty, push, mark_done, free;
  logic hd_is_store, hd_addr_ok, hd_data_ok, hd_done;
  logic [ROB_W-1:0]  hd_rob_id;
  logic [ADDR_W-1:0] hd_addr;
  logic [DATA_W-1:0] hd_data;

  assign disp_ready = !full && !flush;
  assign push       = disp_valid && disp_ready;
  assign disp_tag   = tail_idx;

  memq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(free), .flush(flush),
    .head_idx(head_idx), .tail_idx(tail_idx), .full(full), .empty(empty)
  );

  memq_slots #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROB_W(ROB_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc(push), .tail_idx(tail_idx),
    .alloc_is_store(disp_is_store), .alloc_rob_id(disp_rob_id),
    .addr_wb_valid(addr_wb_valid), .addr_wb_tag(addr_wb_tag), .addr_wb_addr(addr_wb_addr),
    .data_wb_valid(data_wb_valid), .data_wb_tag(data_wb_tag), .data_wb_data(data_wb_data),
    .head_idx(head_idx), .mark_done(mark_done), .free(free),
    .hd_is_store(hd_is_store), .hd_rob_id(hd_rob_id), .hd_addr(hd_addr),
    .hd_data(hd_data), .hd_addr_ok(hd_addr_ok), .hd_data_ok(hd_data_ok), .hd_done(hd_done)
  );

  memq_head #(.ROB_W(ROB_W)) u_head (
    .empty(empty), .flush(flush),
    .hd_is_store(hd_is_store), .hd_rob_id(hd_rob_id),
    .hd_addr_ok(hd_addr_ok), .hd_data_ok(hd_data_ok), .hd_done(hd_done),
    .rob_head_valid(rob_head_valid), .rob_head_id(rob_head_id),
    .req_ready(req_ready), .req_valid(req_valid),
    .mark_done(mark_done), .free(free)
  );

  assign req_is_store = hd_is_store;
  assign req_addr     = hd_addr;
  assign req_data     = hd_data;
  assign req_rob_id   = hd_rob_id;
  assign head_free    = free;
  assign q_empty      = empty;
endmodule

// File: rtl/memq_inorder_chk.sv
module memq_inorder_chk #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned ROB_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              disp_valid,
  input logic              disp_ready,
  input logic              rob_head_valid,
  input logic [ROB_W-1:0]  rob_head_id,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_is_store,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ROB_W-1:0]  req_rob_id,
  input logic              head_free,
  input logic              q_empty
);
  int unsigned occ;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) occ <= 0;
    else occ <= occ + ((disp_valid && disp_ready) ? 1 : 0) - (head_free ? 1 : 0);
  end

  // R2
  full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == DEPTH) |-> !disp_ready);

  // R2
  empty_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_empty == (occ == 0));

  // R6
  store_rob_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_store) |-> (rob_head_valid && rob_head_id == req_rob_id));

  // R6
  store_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_is_store) |-> head_free);

  // R7
  no_free_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    head_free |-> (occ != 0));

  // R8
  load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !flush && !req_is_store) |=> (req_valid && $stable(req_addr)));

  // R9
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> q_empty);

  // R9
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!req_valid && !disp_ready));
endmodule

bind memq_inorder memq_inorder_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .ROB_W(ROB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush),
  .disp_valid(disp_valid), .disp_ready(disp_ready),
  .rob_head_valid(rob_head_valid), .rob_head_id(rob_head_id),
  .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
  .req_addr(req_addr), .req_rob_id(req_rob_id),
  .head_free(head_free), .q_empty(q_empty)
);

// File: tb/test_memq_inorder.sv
`timescale 1ns/1ps
module test_memq_inorder;
  localparam int DEPTH = 4, ADDR_W = 32, DATA_W = 32, ROB_W = 6, IDX_W = 2;

  logic clk = 0, rst_n = 0, flush = 0;
  logic disp_valid = 0, disp_is_store = 0;
  logic [ROB_W-1:0] disp_rob_id = '0;
  logic disp_ready;
  logic [IDX_W-1:0] disp_tag;
  logic addr_wb_valid = 0, data_wb_valid = 0;
  logic [IDX_W-1:0] addr_wb_tag = '0, data_wb_tag = '0;
  logic [ADDR_W-1:0] addr_wb_addr = '0;
  logic [DATA_W-1:0] data_wb_data = '0;
  logic rob_head_valid = 0;
  logic [ROB_W-1:0] rob_head_id = '0;
  logic req_valid, req_ready = 0, req_is_store, head_free, q_empty;
  logic [ADDR_W-1:0] req_addr;
  logic [DATA_W-1:0] req_data;
  logic [ROB_W-1:0] req_rob_id;

  int n_chk = 0, n_fail = 0;
  int m_head = 0, m_tail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  memq_inorder #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ROB_W(ROB_W)) i_memq_inorder (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_is_store(disp_is_store),
    .disp_rob_id(disp_rob_id), .disp_tag(disp_tag),
    .addr_wb_valid(addr_wb_valid), .addr_wb_tag(addr_wb_tag), .addr_wb_addr(addr_wb_addr),
    .data_wb_valid(data_wb_valid), .data_wb_tag(data_wb_tag), .data_wb_data(data_wb_data),
    .rob_head_valid(rob_head_valid), .rob_head_id(rob_head_id),
    .req_valid(req_valid), .req_ready(req_ready), .req_is_store(req_is_store),
    .req_addr(req_addr), .req_data(req_data), .req_rob_id(req_rob_id),
    .head_free(head_free), .q_empty(q_empty)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic dispatch(input bit st, input int rob);
    disp_valid = 1; disp_is_store = st; disp_rob_id = ROB_W'(rob);
    #1;
    chk(disp_ready == 1, "R2", "disp_ready", disp_ready, 1);
    chk(disp_tag == IDX_W'(m_tail), "R2", "disp_tag", disp_tag, m_tail % DEPTH);
    step();
    disp_valid = 0;
    m_tail = (m_tail + 1) % DEPTH;
  endtask

  task automatic wr_addr(input int tag, input int a);
    addr_wb_valid = 1; addr_wb_tag = IDX_W'(tag); addr_wb_addr = ADDR_W'(a);
    step();
    addr_wb_valid = 0;
  endtask

  task automatic wr_data(input int tag, input int d);
    data_wb_valid = 1; data_wb_tag = IDX_W'(tag); data_wb_data = DATA_W'(d);
    step();
    data_wb_valid = 0;
  endtask

  // expects a request with given fields, accepts it
  task automatic take(input string req, input bit st, input int a, input int d, input int rob);
    #1;
    chk(req_valid == 1, req, "req_valid", req_valid, 1);
    chk(req_is_store == st, req, "req_is_store", req_is_store, st);
    chk(req_addr == ADDR_W'(a), req, "req_addr", req_addr, a);
    chk(req_rob_id == ROB_W'(rob), req, "req_rob_id", req_rob_id, rob);
    if (st) chk(req_data == DATA_W'(d), req, "req_data", req_data, d);
    req_ready = 1;
    #1;
    chk(head_free == st, st ? "R6" : "R7", "head_free on accept", head_free, st);
    step();
    req_ready = 0;
    if (st) m_head = (m_head + 1) % DEPTH;
  endtask

  task automatic retire_load(input int rob);
    rob_head_valid = 1; rob_head_id = ROB_W'(rob);
    #1;
    chk(head_free == 1, "R7", "head_free at retire", head_free, 1);
    step();
    rob_head_valid = 0;
    m_head = (m_head + 1) % DEPTH;
  endtask

  task automatic t_reset();
    #1;
    chk(q_empty == 1, "R1", "q_empty", q_empty, 1);
    chk(disp_ready == 1, "R1", "disp_ready", disp_ready, 1);
    chk(req_valid == 0, "R1", "req_valid", req_valid, 0);
    chk(head_free == 0, "R1", "head_free", head_free, 0);
  endtask

  task automatic t_load();
    dispatch(0, 1);
    #1 chk(req_valid == 0, "R5", "no req without addr", req_valid, 0);
    wr_addr(m_head, 'h100);
    take("R5", 0, 'h100, 0, 1);
    #1 chk(req_valid == 0, "R7", "load not reissued", req_valid, 0);
    rob_head_valid = 1; rob_head_id = 6'd9;
    #1 chk(head_free == 0, "R7", "free only at own rob head", head_free, 0);
    rob_head_valid = 0;
    retire_load(1);
    #1 chk(q_empty == 1, "R7", "empty after retire", q_empty, 1);
  endtask

  task automatic t_store();
    int tg;
    tg = m_tail;
    dispatch(1, 2);
    wr_addr(tg, 'h200);
    #1 chk(req_valid == 0, "R6", "store waits for data", req_valid, 0);
    wr_data(tg, 'hCAFE);
    #1 chk(req_valid == 0, "R6", "store waits for rob head", req_valid, 0);
    rob_head_valid = 1; rob_head_id = 6'd3;
    #1 chk(req_valid == 0, "R6", "wrong rob head", req_valid, 0);
    rob_head_id = 6'd2;
    take("R6", 1, 'h200, 'hCAFE, 2);
    rob_head_valid = 0;
    #1 chk(q_empty == 1, "R6", "empty after store", q_empty, 1);
  endtask

  task automatic t_order();
    int t0, t1, t2;
    t0 = m_tail; dispatch(0, 10);
    t1 = m_tail; dispatch(1, 11);
    t2 = m_tail; dispatch(0, 12);
    wr_addr(t2, 'h320);
    wr_data(t1, 'hBEEF);
    wr_addr(t1, 'h310);
    rob_head_valid = 1; rob_head_id = 6'd11;
    #1 chk(req_valid == 0, "R4", "younger ready, head unresolved", req_valid, 0);
    rob_head_valid = 0;
    wr_addr(t0, 'h300);
    take("R4", 0, 'h300, 0, 10);
    #1 chk(req_valid == 0, "R4", "head load awaiting retire blocks younger", req_valid, 0);
    retire_load(10);
    rob_head_valid = 1; rob_head_id = 6'd11;
    take("R4", 1, 'h310, 'hBEEF, 11);
    rob_head_id = 6'd12;
    take("R4", 0, 'h320, 0, 12);
    rob_head_valid = 0;
    retire_load(12);
  endtask

  task automatic t_backpressure();
    int tg;
    tg = m_tail;
    dispatch(0, 20);
    wr_addr(tg, 'h440);
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(req_valid == 1, "R8", "valid held", req_valid, 1);
      chk(req_addr == 'h440, "R8", "addr held", req_addr, 'h440);
      step();
    end
    take("R8", 0, 'h440, 0, 20);
    retire_load(20);
  endtask

  task automatic t_full_flush();
    for (int i = 0; i < DEPTH; i++) dispatch(0, 30 + i);
    #1 chk(disp_ready == 0, "R2", "full stalls dispatch", disp_ready, 0);
    flush = 1;
    #1 chk(req_valid == 0, "R9", "no req during flush", req_valid, 0);
    step();
    flush = 0;
    m_tail = m_head;
    #1;
    chk(q_empty == 1, "R9", "empty after flush", q_empty, 1);
    chk(disp_ready == 1, "R9", "ready after flush", disp_ready, 1);
    chk(req_valid == 0, "R9", "no req after flush", req_valid, 0);
    // stale writeback to a slot with no entry
    wr_addr(m_tail, 'h999);
    #1 chk(q_empty == 1, "R3", "stale wb keeps empty", q_empty, 1);
    dispatch(0, 40);
    #1 chk(req_valid == 0, "R3", "stale wb had no effect", req_valid, 0);
    wr_addr(m_head, 'h500);
    take("R3", 0, 'h500, 0, 40);
    retire_load(40);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    step();
    t_reset();
    t_load();
    t_store();
    t_order();
    t_backpressure();
    t_full_flush();
    t_order();
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule